// File: doc/BRIEF.md
# Double Late Write Burst SRAM

A synchronous single-port static memory that keeps its shared data bus busy on every cycle. Reads are pipelined and return data one edge after the command edge. Write data is taken two edges after the write command. Because of this offset, a read followed by a write, or a write followed by a read, needs no idle turnaround cycle. Commands are sampled on the rising clock edge. A command begins only when the advance input is low. While advance is high, the current access continues as a four-beat linear burst that wraps within an aligned group of four words.

The block has three chip enables. The first is active low. The other two have a sense set by a pair of static program inputs. With these, four identical instances can share one bus and be decoded by two address bits. A bank that is not selected turns off both its data drive and its echo clock. A deselect through the first enable turns off only the data drive. The tri-state data bus is modelled as a data vector plus an output enable. Per-byte write strobes are active low. A write beat with every strobe high writes nothing. A read issued one cycle after a write to the same word returns the merged new data, even though that data has not yet reached the array.

Top module: `dlw_sram`

## Requirements
- R1: A command edge with adv_i=0, e1_ni=0, the bank enable true and we_ni=1 is a read. After the next rising edge, q_oe_o=1 and q_o holds the addressed word.
- R2: A command edge with adv_i=0, e1_ni=0, the bank enable true and we_ni=0 is a write. The data is sampled from d_i two rising edges after the command edge. Byte lane b (bits 8b+7..8b) is written only when bw_ni[b]=0 at the command or beat edge.
- R3: An edge with adv_i=1 continues the previous operation kind. Address bits [1:0] advance by one modulo 4 from the previous beat, and the upper address bits are held. On such an edge e1_ni, e2_i, e3_i, we_ni and addr_i are ignored.
- R4: The bank enable is true only when e2_i==ep2_i and e3_i==ep3_i. A command edge where it is false is a bank deselect, whatever the value of e1_ni. A bank deselect and its continues give q_oe_o=0 and cq_en_o=0 after the next edge.
- R5: A write beat with bw_ni all ones is an abort and leaves the memory unchanged.
- R6: After a deselect (adv_i=0, bank enable true, e1_ni=1) or a write beat, q_oe_o=0 after the next edge.
- R7: After a read, write or e1_ni deselect, cq_en_o=1 after the next edge.
- R8: A read returns the data of every write whose command edge came before the read's command edge. This includes a write commanded on the edge just before the read, whose data arrives on the same edge the read is output.
- R9: An active-low asynchronous reset forces q_oe_o=0 and cq_en_o=0 and drops any write whose data has not yet been taken. A continue edge (adv_i=1) right after reset acts as an e1_ni deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Start word address of a command |
| e1_ni | input | 1 | Chip enable, active low |
| e2_i | input | 1 | Programmable-sense enable, compared with ep2_i |
| e3_i | input | 1 | Programmable-sense enable, compared with ep3_i |
| ep2_i | input | 1 | Static program input setting the sense of e2_i |
| ep3_i | input | 1 | Static program input setting the sense of e3_i |
| adv_i | input | 1 | 0 starts a command, 1 continues the burst |
| we_ni | input | 1 | 0 write, 1 read |
| bw_ni | input | NB | Byte write strobes, active low |
| d_i | input | NB*BYTE_W | Write data, two edges after its beat |
| q_o | output | NB*BYTE_W | Read data, zero when not driven |
| q_oe_o | output | 1 | Data bus drive enable |
| cq_en_o | output | 1 | Echo clock drive enable |

## Verification
Read data and both enables are due after the single edge that follows the command or beat edge. Write data is taken from d_i two edges after its beat, and it reaches a later read's output on that same edge. The bench drives a beat at the falling edge and predicts its outputs from a two-deep history of beats. It checks the outputs at the falling edge after the next rising edge, so every output check lands exactly one cycle after its stimulus. A reference memory is updated when each write's data is driven, before the expected read value is formed. This ordering covers forwarding with no special case.

// File: rtl/dlw_pkg.sv
package dlw_pkg;
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_DESEL,
    OP_BANK,
    OP_READ,
    OP_WRITE
  } op_e;
endpackage

// File: rtl/dlw_cmd_decode.sv
module dlw_cmd_decode
  import dlw_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          e1_ni,
  input  logic          e2_i,
  input  logic          e3_i,
  input  logic          ep2_i,
  input  logic          ep3_i,
  input  logic          adv_i,
  input  logic          we_ni,
  input  logic [NB-1:0] bw_ni,
  output op_e           op_o,
  output logic [AW-1:0] addr_o,
  output logic [NB-1:0] bw_o
);
  logic          en_ok;
  op_e           op_n;
  logic [AW-1:0] addr_n;

  assign en_ok = (e2_i == ep2_i) && (e3_i == ep3_i);

  always_comb begin
    if (!adv_i) begin
      addr_n = addr_i;
      if (!en_ok)     op_n = OP_BANK;  // bank select outranks e1
      else if (e1_ni) op_n = OP_DESEL;
      else if (we_ni) op_n = OP_READ;
      else            op_n = OP_WRITE;
    end else begin
      op_n   = (op_o == OP_IDLE) ? OP_DESEL : op_o;
      addr_n = {addr_o[AW-1:2], addr_o[1:0] + 2'd1};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_o   <= OP_IDLE;
      addr_o <= '0;
      bw_o   <= '1;
    end else begin
      op_o   <= op_n;
      addr_o <= addr_n;
      bw_o   <= bw_ni;
    end
  end

  // R3: continue keeps kind, steps low bits, holds upper bits
  p_burst_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && op_o != OP_IDLE) |=>
      (op_o == $past(op_o) && addr_o[1:0] == $past(addr_o[1:0]) + 2'd1
       && $stable(addr_o[AW-1:2])));
endmodule

// File: rtl/dlw_write_pipe.sv
module dlw_write_pipe
  import dlw_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  op_e           op_i,
  input  logic [AW-1:0] addr_i,
  input  logic [NB-1:0] bw_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [NB-1:0] wr_bw_o
);
  // second pending stage: commit happens on the following edge with d_i
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_bw_o   <= '1;
    end else begin
      wr_en_o   <= (op_i == OP_WRITE);
      wr_addr_o <= addr_i;
      wr_bw_o   <= bw_i;
    end
  end
endmodule

// File: rtl/dlw_array.sv
module dlw_array
  import dlw_pkg::*;
#(
  parameter int AW     = 6,
  parameter int NB     = 4,
  parameter int BYTE_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  op_e                  rd_op_i,
  input  logic [AW-1:0]        rd_addr_i,
  input  logic                 wr_en_i,
  input  logic [AW-1:0]        wr_addr_i,
  input  logic [NB-1:0]        wr_bw_i,
  input  logic [NB*BYTE_W-1:0] wr_data_i,
  output logic [NB*BYTE_W-1:0] q_o,
  output logic                 q_oe_o,
  output logic                 cq_en_o
);
  localparam int DW    = NB * BYTE_W;
  localparam int DEPTH = 1 << AW;

  logic          hit;
  logic [DW-1:0] rd_word;

  assign hit = wr_en_i && (wr_addr_i == rd_addr_i);

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [BYTE_W-1:0] lane_mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (wr_en_i && !wr_bw_i[b])
        lane_mem[wr_addr_i] <= wr_data_i[b*BYTE_W +: BYTE_W];
    end

    // same-edge commit is forwarded into the read
    assign rd_word[b*BYTE_W +: BYTE_W] = (hit && !wr_bw_i[b]) ?
        wr_data_i[b*BYTE_W +: BYTE_W] : lane_mem[rd_addr_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o     <= '0;
      q_oe_o  <= 1'b0;
      cq_en_o <= 1'b0;
    end else begin
      q_oe_o  <= (rd_op_i == OP_READ);
      q_o     <= (rd_op_i == OP_READ) ? rd_word : '0;
      cq_en_o <= !(rd_op_i == OP_BANK || rd_op_i == OP_IDLE);
    end
  end

  // R8: a full-word commit on the read's edge appears on the output
  p_fwd_full_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_op_i == OP_READ && wr_en_i && wr_addr_i == rd_addr_i && wr_bw_i == '0)
      |=> (q_oe_o && q_o == $past(wr_data_i)));
endmodule

// File: rtl/dlw_sram.sv
module dlw_sram
  import dlw_pkg::*;
#(
  parameter int AW     = 6,
  parameter int NB     = 4,
  parameter int BYTE_W = 8,
  localparam int DW    = NB * BYTE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          e1_ni,
  input  logic          e2_i,
  input  logic          e3_i,
  input  logic          ep2_i,
  input  logic          ep3_i,
  input  logic          adv_i,
  input  logic          we_ni,
  input  logic [NB-1:0] bw_ni,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o,
  output logic          q_oe_o,
  output logic          cq_en_o
);
  op_e           s1_op;
  logic [AW-1:0] s1_addr;
  logic [NB-1:0] s1_bw;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [NB-1:0] wr_bw;

  dlw_cmd_decode #(.AW(AW), .NB(NB)) u_decode (
    .clk_i (clk_i), .rst_ni (rst_ni), .addr_i (addr_i),
    .e1_ni (e1_ni), .e2_i (e2_i), .e3_i (e3_i),
    .ep2_i (ep2_i), .ep3_i (ep3_i), .adv_i (adv_i),
    .we_ni (we_ni), .bw_ni (bw_ni),
    .op_o  (s1_op), .addr_o (s1_addr), .bw_o (s1_bw)
  );

  dlw_write_pipe #(.AW(AW), .NB(NB)) u_wpipe (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .op_i (s1_op), .addr_i (s1_addr), .bw_i (s1_bw),
    .wr_en_o (wr_en), .wr_addr_o (wr_addr), .wr_bw_o (wr_bw)
  );

  dlw_array #(.AW(AW), .NB(NB), .BYTE_W(BYTE_W)) u_array (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .rd_op_i (s1_op), .rd_addr_i (s1_addr),
    .wr_en_i (wr_en), .wr_addr_i (wr_addr), .wr_bw_i (wr_bw),
    .wr_data_i (d_i),
    .q_o (q_o), .q_oe_o (q_oe_o), .cq_en_o (cq_en_o)
  );

  logic en_ok;
  assign en_ok = (e2_i == ep2_i) && (e3_i == ep3_i);

  p_read_drive_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && en_ok && !e1_ni && we_ni) |-> ##2 q_oe_o);

  p_write_hiz_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && en_ok && !e1_ni && !we_ni) |-> ##2 (!q_oe_o && cq_en_o));

  p_bank_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !en_ok) |-> ##2 (!cq_en_o && !q_oe_o));

  p_desel_cq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && en_ok && e1_ni) |-> ##2 (cq_en_o && !q_oe_o));
endmodule

// File: tb/tb_dlw_sram.sv
`timescale 1ns/1ps
module tb_dlw_sram;
  import dlw_pkg::*;
  localparam int AW = 6, NB = 4, BYTE_W = 8, DW = NB * BYTE_W, DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_ni;
  logic [AW-1:0] addr_i;
  logic e1_ni, e2_i, e3_i, ep2_i, ep3_i, adv_i, we_ni;
  logic [NB-1:0] bw_ni;
  logic [DW-1:0] d_i, q_o;
  logic q_oe_o, cq_en_o;

  always #2.5 clk = ~clk;

  dlw_sram #(.AW(AW), .NB(NB), .BYTE_W(BYTE_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .e1_ni(e1_ni),
    .e2_i(e2_i), .e3_i(e3_i), .ep2_i(ep2_i), .ep3_i(ep3_i),
    .adv_i(adv_i), .we_ni(we_ni), .bw_ni(bw_ni), .d_i(d_i),
    .q_o(q_o), .q_oe_o(q_oe_o), .cq_en_o(cq_en_o)
  );

  int checks = 0, errors = 0;
  logic [DW-1:0] ref_mem [DEPTH];
  op_e h1_op, h2_op;
  logic [AW-1:0] h1_addr, h2_addr;
  logic [NB-1:0] h1_bw, h2_bw;
  string h1_tag, h2_tag, next_tag = "";
  logic exp_oe, exp_cq;
  logic [DW-1:0] exp_q;
  string exp_oe_tag = "R9", exp_q_tag = "R1";

  task automatic chk(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare();
    chk(exp_oe_tag, DW'(q_oe_o), DW'(exp_oe));
    chk((exp_oe_tag == "R4" || exp_oe_tag == "R9") ? exp_oe_tag : "R7",
        DW'(cq_en_o), DW'(exp_cq));
    if (exp_oe) chk(exp_q_tag, q_o, exp_q);
  endtask

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw,
                                          logic [NB-1:0] bwn);
    logic [DW-1:0] r = old;
    for (int b = 0; b < NB; b++)
      if (!bwn[b]) r[b*BYTE_W +: BYTE_W] = nw[b*BYTE_W +: BYTE_W];
    return r;
  endfunction

  // one beat: check previous result, drive, predict, advance one clock
  task automatic cyc(bit adv, bit e1n, bit e2, bit e3, bit wen,
                     logic [NB-1:0] bwn, logic [AW-1:0] a);
    op_e op;
    logic [AW-1:0] ad;
    bit fwd;
    compare();
    adv_i = adv; e1_ni = e1n; e2_i = e2; e3_i = e3; we_ni = wen;
    bw_ni = bwn; addr_i = a; d_i = $urandom;
    if (!adv) begin
      ad = a;
      if (e2 != ep2_i || e3 != ep3_i) op = OP_BANK;
      else if (e1n) op = OP_DESEL;
      else op = wen ? OP_READ : OP_WRITE;
    end else begin
      op = (h1_op == OP_IDLE) ? OP_DESEL : h1_op;
      ad = {h1_addr[AW-1:2], h1_addr[1:0] + 2'd1};
    end
    fwd = (h2_op == OP_WRITE) && (h2_addr == h1_addr) && (h2_bw != '1);
    if (h2_op == OP_WRITE) ref_mem[h2_addr] = merge(ref_mem[h2_addr], d_i, h2_bw);
    exp_oe = (h1_op == OP_READ);
    exp_cq = !(h1_op == OP_BANK || h1_op == OP_IDLE);
    exp_q  = ref_mem[h1_addr];
    if (h1_tag != "") begin
      exp_oe_tag = h1_tag; exp_q_tag = h1_tag;
    end else begin
      case (h1_op)
        OP_READ:  exp_oe_tag = "R1";
        OP_BANK:  exp_oe_tag = "R4";
        OP_IDLE:  exp_oe_tag = "R9";
        default:  exp_oe_tag = "R6";
      endcase
      exp_q_tag = fwd ? "R8" : "R1";
    end
    h2_op = h1_op; h2_addr = h1_addr; h2_bw = h1_bw; h2_tag = h1_tag;
    h1_op = op; h1_addr = ad; h1_bw = bwn; h1_tag = next_tag;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [NB-1:0] bwn);
    cyc(1'b0, 1'b0, ep2_i, ep3_i, 1'b0, bwn, a);
  endtask
  task automatic rd(logic [AW-1:0] a);
    cyc(1'b0, 1'b0, ep2_i, ep3_i, 1'b1, '1, a);
  endtask
  task automatic ds();
    cyc(1'b0, 1'b1, ep2_i, ep3_i, 1'b1, '1, '0);
  endtask
  task automatic cont(logic [NB-1:0] bwn);
    cyc(1'b1, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), bwn,
        AW'($urandom));
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    #1;
    chk("R9", DW'(q_oe_o), '0);
    chk("R9", DW'(cq_en_o), '0);
    h1_op = OP_IDLE; h2_op = OP_IDLE; h1_tag = ""; h2_tag = "";
    h1_addr = '0; h2_addr = '0; h1_bw = '1; h2_bw = '1;
    exp_oe = 1'b0; exp_cq = 1'b0; exp_oe_tag = "R9"; exp_q_tag = "R9";
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5eed_0d1a);
    rst_ni = 1'b1; ep2_i = 1'b0; ep3_i = 1'b1;
    adv_i = 1'b0; e1_ni = 1'b1; e2_i = 1'b0; e3_i = 1'b1; we_ni = 1'b1;
    bw_ni = '1; addr_i = '0; d_i = '0;
    #1;
    do_reset();

    // fill memory with full-word write bursts
    for (int base = 0; base < DEPTH; base += 4) begin
      wr(AW'(base), '0);
      repeat (3) cont('0);
    end
    ds(); ds();

    // R3: read burst starting at low bits 10, wraps, fifth beat repeats start
    next_tag = "R3";
    rd(6'd6); repeat (4) cont('1);
    next_tag = "";
    ds();

    // R2: partial write, bytes 0 and 2 only
    next_tag = "R2";
    wr(6'd10, 4'b1010); ds(); ds(); rd(6'd10);
    next_tag = ""; ds();

    // R5: abort
    next_tag = "R5";
    wr(6'd11, 4'b1111); ds(); ds(); rd(6'd11);
    next_tag = ""; ds();

    // R4: bank deselect outranks e1; continues and read attempts stay off
    next_tag = "R4";
    cyc(1'b0, 1'b1, ~ep2_i, ep3_i, 1'b1, '1, 6'd3);
    cyc(1'b1, 1'b0, ep2_i, ep3_i, 1'b1, '1, 6'd3);
    cyc(1'b0, 1'b0, ep2_i, ~ep3_i, 1'b1, '1, 6'd3);
    next_tag = ""; ds(); ds();

    // R8: read right after write, full and partial
    next_tag = "R8";
    wr(6'd20, '0); rd(6'd20);
    wr(6'd21, 4'b0011); rd(6'd21);
    wr(6'd24, '0); repeat (3) cont('0); rd(6'd27); rd(6'd24);
    next_tag = ""; ds(); ds();

    // R3: write burst with noisy control on continues, then read back
    next_tag = "R3";
    wr(6'd33, '0); repeat (3) cont(4'b0101);
    ds(); ds(); rd(6'd32); repeat (3) cont('1);
    next_tag = ""; ds();

    // R9: reset drops a pending write; continue after reset is a deselect
    wr(6'd40, '0);
    do_reset();
    next_tag = "R9";
    cont('1); rd(6'd40);
    next_tag = ""; ds();

    // random phases with two program settings
    for (int ph = 0; ph < 2; ph++) begin
      ep2_i = ph[0]; ep3_i = ~ph[0];
      ds(); ds();
      for (int i = 0; i < 1500; i++) begin
        bit adv, mis, sel;
        logic [NB-1:0] bwn;
        adv = ($urandom % 10) < 3;
        mis = ($urandom % 6) == 0;
        sel = 1'($urandom);
        bwn = (($urandom % 5) == 0) ? '1 : NB'($urandom);
        cyc(adv, ($urandom % 8) == 0, ep2_i ^ (mis & sel), ep3_i ^ (mis & ~sel),
            1'($urandom), bwn, AW'($urandom % 16));
      end
    end
    ds(); ds();
    compare();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule